// File: doc/BRIEF.md
# Ring Buffer Write Splitter

This block sits in front of a memory write port that feeds a circular buffer held in memory. A client asks to write a run of bytes at some address. The block folds that address into the buffer window, which is described by two configuration words: a base address and a size mask. It then emits one or two contiguous write commands, each an address and byte-length pair. The block moves no data. It only decides where the bytes land and how the run is broken up.

The effective start is the base plus the requested address ANDed with the mask. The ring ends one 16-byte quadword past base plus mask. A run that stays below that end produces one command. A run that reaches or passes the end is cut into two pieces: a tail piece that runs from the start up to the end, and a wrapped piece that restarts at the base and carries the remaining bytes. When the wrapped piece would be empty, only the tail piece is issued. Each request is followed by a one-cycle completion pulse. The block accepts no new request until that pulse has been given.

Top module: `ring_wr_split`

## Requirements
- R1: After reset, req_ready is 1, and cmd_valid and done are 0. req_ready is never high while cmd_valid is high.
- R2: When start + length is below limit, exactly one command is issued, with cmd_addr = start and cmd_len = length. Here start = cfg_base + (req_addr & cfg_mask) and limit = cfg_base + cfg_mask + 16.
- R3: When start + length is greater than limit, the first command has cmd_addr = start and cmd_len = limit - start.
- R4: The second command of a split request has cmd_addr = cfg_base and cmd_len = length - (limit - start).
- R5: When start + length equals limit exactly, only one command is issued, with cmd_addr = start and cmd_len = length.
- R6: While cmd_valid is 1 and cmd_ready is 0, cmd_valid stays 1 and cmd_addr and cmd_len do not change.
- R7: done is high for exactly one cycle per request, in the cycle right after the handshake of that request's last command.
- R8: req_ready is 0 from the cycle after a request is accepted until the cycle after done. A req_valid asserted in that window produces no command.
- R9: Bits of req_addr that are zero in cfg_mask have no effect on cmd_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle; request taken when both are high |
| req_addr | input | AW | Requested write address (folded by the mask) |
| req_len | input | AW | Requested byte count, a multiple of 16 |
| cfg_base | input | AW | Ring base address |
| cfg_mask | input | AW | Ring size mask (ring size minus 16) |
| cmd_valid | output | 1 | Write command present |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_addr | output | AW | Command start address |
| cmd_len | output | AW | Command byte count |
| done | output | 1 | One-cycle pulse after the last command of a request |

## Verification
The assertions assume that every request length is nonzero, and that neither base + mask + 16 nor start + length wraps past 2^32. They also assume that the low four bits of the mask are zero, so that pieces stay quadword sized. The stimulus uses two ring configurations whose limits sit well below the top of the address space, and lengths that are multiples of 16 no larger than the ring. It drives junk requests only while the block is busy. It varies cmd_ready between always-ready and one-in-three patterns, so that stalls land on both the tail piece and the wrapped piece.

// File: rtl/ring_split_pkg.sv
package ring_split_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAD = 2'd1,
    ST_WRAP = 2'd2,
    ST_DONE = 2'd3
  } split_state_e;
endpackage

// File: rtl/ring_span_calc.sv
module ring_span_calc #(
  parameter int AW  = 32,
  parameter int QWB = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] head_q,
  output logic [AW-1:0] tail_q,
  output logic [AW-1:0] base_q,
  output logic          two_q
);
  localparam logic [AW-1:0] QW_INC = AW'(QWB);

  logic [AW-1:0] start_c, limit_c, end_c, head_c, tail_c;
  logic          cross_c;

  always_comb begin
    start_c = base + (addr & mask);
    limit_c = base + mask + QW_INC;
    end_c   = start_c + len;
    cross_c = (end_c >= limit_c);
    head_c  = cross_c ? (limit_c - start_c) : len;
    tail_c  = cross_c ? (len - head_c) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      base_q  <= '0;
      two_q   <= 1'b0;
    end else if (load) begin
      start_q <= start_c;
      head_q  <= head_c;
      tail_q  <= tail_c;
      base_q  <= base;
      two_q   <= cross_c && (tail_c != '0);
    end
  end
endmodule

// File: rtl/ring_cmd_fsm.sv
module ring_cmd_fsm
  import ring_split_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic cmd_ready,
  input  logic two,
  output logic req_ready,
  output logic load,
  output logic cmd_valid,
  output logic sel_wrap,
  output logic done
);
  split_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_HEAD;
      ST_HEAD: if (cmd_ready) state_d = two ? ST_WRAP : ST_DONE;
      ST_WRAP: if (cmd_ready) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign load      = req_valid && req_ready;
  assign cmd_valid = (state_q == ST_HEAD) || (state_q == ST_WRAP);
  assign sel_wrap  = (state_q == ST_WRAP);
  assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/ring_wr_split.sv
module ring_wr_split #(
  parameter int AW  = 32,
  parameter int QWB = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] req_len,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_mask,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [AW-1:0] cmd_addr,
  output logic [AW-1:0] cmd_len,
  output logic          done
);
  logic          load, sel_wrap, two;
  logic [AW-1:0] start_q, head_q, tail_q, base_q;

  ring_span_calc #(.AW(AW), .QWB(QWB)) u_calc (
    .clk(clk), .rst(rst), .load(load),
    .addr(req_addr), .len(req_len), .base(cfg_base), .mask(cfg_mask),
    .start_q(start_q), .head_q(head_q), .tail_q(tail_q),
    .base_q(base_q), .two_q(two)
  );

  ring_cmd_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .cmd_ready(cmd_ready),
    .two(two), .req_ready(req_ready), .load(load), .cmd_valid(cmd_valid),
    .sel_wrap(sel_wrap), .done(done)
  );

  // The second piece always restarts at the captured ring base.
  assign cmd_addr = sel_wrap ? base_q : start_q;
  assign cmd_len  = sel_wrap ? tail_q : head_q;
endmodule

// File: rtl/ring_wr_split_chk.sv
module ring_wr_split_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] cfg_base,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [AW-1:0] cmd_addr,
  input logic [AW-1:0] cmd_len,
  input logic          done
);
  logic [AW-1:0] base_cap;
  logic          hs_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_cap <= '0;
      hs_seen  <= 1'b0;
    end else if (req_valid && req_ready) begin
      base_cap <= cfg_base;
      hs_seen  <= 1'b0;
    end else if (cmd_valid && cmd_ready) begin
      hs_seen  <= 1'b1;
    end
  end

  p_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && cmd_valid));

  p_nonempty_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_len != '0));

  p_wrap_base_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && hs_seen) |-> (cmd_addr == base_cap));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_hs_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(cmd_valid && cmd_ready));

  p_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind ring_wr_split ring_wr_split_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_ring_wr_split.sv
`timescale 1ns/1ps
module test_ring_wr_split;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [AW-1:0] req_len = '0;
  logic [AW-1:0] cfg_base = '0;
  logic [AW-1:0] cfg_mask = '0;
  logic          cmd_valid;
  logic          cmd_ready = 1'b1;
  logic [AW-1:0] cmd_addr;
  logic [AW-1:0] cmd_len;
  logic          done;

  always #2.5 clk = ~clk;

  ring_wr_split #(.AW(AW)) i_ring_wr_split (.*);

  int checks = 0;
  int fails = 0;
  int sent = 0;
  int done_cnt = 0;
  int rdy_mode = 0;
  bit finished = 0;

  logic [AW-1:0] exp_addr[$];
  logic [AW-1:0] exp_len[$];
  string         exp_tag[$];

  task automatic check(input bit ok, input string tag, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Ready pattern: mode 0 always ready, mode 1 ready one cycle in three.
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      cmd_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
    end
  end

  // Monitor / scoreboard
  logic          prev_hs = 0, prev_stall = 0;
  logic [AW-1:0] prev_addr = '0, prev_len = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        check(cmd_valid, "R6 valid held", {31'd0, cmd_valid}, 1);
        check(cmd_addr == prev_addr && cmd_len == prev_len, "R6 cmd stable",
              cmd_addr, prev_addr);
      end
      if (cmd_valid && cmd_ready) begin
        if (exp_addr.size() == 0) begin
          check(0, "R8 unexpected command", cmd_addr, '0);
        end else begin
          logic [AW-1:0] ea, el;
          string t;
          ea = exp_addr.pop_front();
          el = exp_len.pop_front();
          t  = exp_tag.pop_front();
          check(cmd_addr == ea, {t, " addr"}, cmd_addr, ea);
          check(cmd_len == el, {t, " len"}, cmd_len, el);
        end
      end
      if (done) begin
        done_cnt++;
        check(prev_hs && exp_addr.size() == 0, "R7 done after last handshake",
              {31'd0, prev_hs}, 1);
      end
      prev_hs    = cmd_valid && cmd_ready;
      prev_stall = cmd_valid && !cmd_ready;
      prev_addr  = cmd_addr;
      prev_len   = cmd_len;
    end
  end

  task automatic push(input logic [AW-1:0] a, input logic [AW-1:0] l, input string t);
    exp_addr.push_back(a);
    exp_len.push_back(l);
    exp_tag.push_back(t);
  endtask

  // Drive one request; expected pieces were pushed by the caller.
  // A junk request is held during the first busy cycle (R8).
  task automatic send(input logic [AW-1:0] a, input logic [AW-1:0] l);
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_len = l;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    sent++;
    req_addr = 32'hDEAD_0000; req_len = 32'h10;
    @(negedge clk);
    check(!req_ready, "R8 busy after accept", {31'd0, req_ready}, 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    do @(negedge clk); while (done_cnt != sent);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 reset req_ready", {31'd0, req_ready}, 1);
    check(cmd_valid == 1'b0, "R1 reset cmd_valid", {31'd0, cmd_valid}, 0);
    check(done == 1'b0, "R1 reset done", {31'd0, done}, 0);

    // Ring A: base 0x1000, mask 0xFF0, limit 0x2000
    cfg_base = 32'h0000_1000; cfg_mask = 32'h0000_0FF0;
    push(32'h1040, 32'h40, "R2 single");              send(32'h40, 32'h40);
    push(32'h1100, 32'h20, "R9 masked addr");         send(32'hABCD_0100, 32'h20);
    push(32'h1FC0, 32'h40, "R3 tail piece");
    push(32'h1000, 32'h40, "R4 wrapped piece");       send(32'h0FC0, 32'h80);
    push(32'h1F00, 32'h100, "R5 exact end");          send(32'h0F00, 32'h100);

    rdy_mode = 1;
    push(32'h1FF0, 32'h10, "R3 tail stalled");
    push(32'h1000, 32'h30, "R4 wrap stalled");        send(32'hFFF0, 32'h40);
    push(32'h1200, 32'h30, "R2 single stalled");      send(32'h0200, 32'h30);

    // Ring B: base 0x8000_0000, mask 0x3F0, limit 0x8000_0400
    cfg_base = 32'h8000_0000; cfg_mask = 32'h0000_03F0;
    push(32'h8000_03F0, 32'h10, "R3 tail B");
    push(32'h8000_0000, 32'h20, "R4 wrap B");         send(32'h3F0, 32'h30);
    rdy_mode = 0;
    push(32'h8000_0010, 32'h3F0, "R5 exact end B");   send(32'h10, 32'h3F0);
    push(32'h8000_0000, 32'h400, "R5 full ring");     send(32'h0, 32'h400);
    push(32'h8000_03E0, 32'h10, "R2 single B");       send(32'h7777_07E0, 32'h10);

    repeat (4) @(negedge clk);
    check(done_cnt == sent, "R7 one done per request", done_cnt, sent);
    check(exp_addr.size() == 0, "R2 all commands seen", exp_addr.size(), 0);
    finished = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      report();
    end
  end
endmodule